// File: doc/BRIEF.md
# RISC Instruction Control Decoder

This block is the purely combinational control decoder of a small 32-bit load/store processor core with 21 instructions. It takes one instruction word and returns, in the same cycle, a one-hot operation vector with one bit per instruction, an immediate-select flag and a register write-back flag. It also returns the register specifiers, the expanded 32-bit immediate and the byte-scaled branch offset.

The instruction word uses three formats. In the register and immediate formats, the top five bits hold the opcode. Next come an immediate-select bit, a destination field and two source fields, or an 18-bit immediate field in place of the second source. In the branch format, the opcode is followed by a 27-bit word offset. The block maps the implicit registers of call, return and store onto its outputs. Downstream stages can therefore use the specifier ports without knowing the instruction.

An opcode outside the defined set clears every flag. The instruction then passes through the core as a no-operation.

Top module: `risc_ctrl_decoder`

## Requirements
- R1: The opcode is instruction bits [31:27]. For a defined code k (0..20), op_onehot_o has exactly bit k set, with this map: 0 add, 1 sub, 2 mul, 3 div, 4 mod, 5 cmp, 6 and, 7 or, 8 not, 9 mov, 10 lsl, 11 lsr, 12 asr, 13 nop, 14 ld, 15 st, 16 beq, 17 bgt, 18 b, 19 call, 20 ret.
- R2: Opcodes 21 to 31 drive op_onehot_o, is_imm_o and is_wb_o all to zero.
- R3: For the three-address operations (codes 0 to 12, ld and st), is_imm_o equals instruction bit 26. For every other opcode it is zero.
- R4: is_wb_o is 1 for add, sub, mul, div, mod, and, or, not, lsl, lsr, asr, mov, ld and call. It is 0 for all other opcodes.
- R5: rs1_o is bits [21:18] and rs2_o is bits [17:14]. rd_o is bits [25:22], except for call, where rd_o is 15, the return-address register.
- R6: For ret, rs1_o is 15. For st, rs2_o carries bits [25:22], the register holding the data to store.
- R7: When bit 17 (h) is 0 and bit 16 (u) is 0, imm_o is bits [15:0] sign-extended to 32 bits.
- R8: When h is 0 and u is 1, imm_o is bits [15:0] zero-extended.
- R9: When h is 1, imm_o holds bits [15:0] in its upper half and zeros in its lower half, whatever the value of u.
- R10: br_off_o is bits [26:0] sign-extended to 32 bits and multiplied by four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| op_onehot_o | output | 21 | One bit per defined operation, indexed by opcode |
| is_imm_o | output | 1 | Second operand comes from imm_o |
| is_wb_o | output | 1 | Instruction writes register rd_o |
| rd_o | output | 4 | Destination register (15 for call) |
| rs1_o | output | 4 | First source register (15 for ret) |
| rs2_o | output | 4 | Second source register (data register for st) |
| imm_o | output | 32 | Expanded immediate |
| br_off_o | output | 32 | Sign-extended byte offset for branches |

## Verification
The decoder holds no state, so any internal error appears on the ports in the same cycle as the instruction word that exposes it. There is no later symptom to wait for. The main risks are a misplaced bit in an opcode mask or a wrong bit slice. A mask error flips is_wb_o or is_imm_o for a single opcode. A slice error shifts a register or immediate field. Each of these shows only for the opcodes or modifier combinations that reach it. For that reason, every opcode is crossed with all four modifier settings and with scattered field values.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  localparam int unsigned OP_W    = 5;
  localparam int unsigned NUM_OPS = 21;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_SUB  = 5'd1,  OP_MUL  = 5'd2,  OP_DIV = 5'd3,
    OP_MOD  = 5'd4,  OP_CMP  = 5'd5,  OP_AND  = 5'd6,  OP_OR  = 5'd7,
    OP_NOT  = 5'd8,  OP_MOV  = 5'd9,  OP_LSL  = 5'd10, OP_LSR = 5'd11,
    OP_ASR  = 5'd12, OP_NOP  = 5'd13, OP_LD   = 5'd14, OP_ST  = 5'd15,
    OP_BEQ  = 5'd16, OP_BGT  = 5'd17, OP_B    = 5'd18, OP_CALL = 5'd19,
    OP_RET  = 5'd20
  } op_e;

  // operations that write a register: alu ops, mov, ld, call
  localparam logic [NUM_OPS-1:0] WB_MASK  = 21'b0100001_0111111_1011111;
  // three-address operations that may take an immediate operand
  localparam logic [NUM_OPS-1:0] IMM_MASK = 21'b0000011_0111111_1111111;
endpackage

// File: rtl/rcd_op_decode.sv
module rcd_op_decode
  import rcd_pkg::*;
(
  input  logic [OP_W-1:0]    opcode_i,
  input  logic               imm_bit_i,
  output logic [NUM_OPS-1:0] onehot_o,
  output logic               is_imm_o,
  output logic               is_wb_o
);
  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    assign onehot_o[k] = (opcode_i == OP_W'(k));
  end

  assign is_wb_o  = |(onehot_o & WB_MASK);
  assign is_imm_o = imm_bit_i & (|(onehot_o & IMM_MASK));

  always_comb begin
    // R1
    onehot_chk: assert ($onehot0(onehot_o))
      else $error("op vector not one-hot");
    // R2
    undef_quiet_chk: assert (!(opcode_i >= OP_W'(NUM_OPS)) || (!is_wb_o && !is_imm_o))
      else $error("undefined opcode raised a flag");
  end
endmodule

// File: rtl/rcd_fields.sv
module rcd_fields #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OP_W  = 5,
  parameter int unsigned REG_W = 4
) (
  input  logic [XLEN-1:0]  instr_i,
  input  logic             is_call_i,
  input  logic             is_ret_i,
  input  logic             is_st_i,
  output logic [REG_W-1:0] rd_o,
  output logic [REG_W-1:0] rs1_o,
  output logic [REG_W-1:0] rs2_o
);
  localparam int unsigned RD_HI  = XLEN - OP_W - 2;
  localparam int unsigned RS1_HI = RD_HI - REG_W;
  localparam int unsigned RS2_HI = RS1_HI - REG_W;
  localparam logic [REG_W-1:0] RA_REG = '1;

  logic [REG_W-1:0] rd_fld, rs1_fld, rs2_fld;
  assign rd_fld  = instr_i[RD_HI  -: REG_W];
  assign rs1_fld = instr_i[RS1_HI -: REG_W];
  assign rs2_fld = instr_i[RS2_HI -: REG_W];

  assign rd_o  = is_call_i ? RA_REG : rd_fld;
  assign rs1_o = is_ret_i  ? RA_REG : rs1_fld;
  assign rs2_o = is_st_i   ? rd_fld : rs2_fld;

  always_comb begin
    // R5
    call_ra_chk: assert (!is_call_i || rd_o == RA_REG)
      else $error("call not targeting return register");
    // R6
    ret_ra_chk: assert (!is_ret_i || rs1_o == RA_REG)
      else $error("ret not reading return register");
  end
endmodule

// File: rtl/rcd_imm.sv
module rcd_imm #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OP_W  = 5,
  parameter int unsigned IMM_W = 16
) (
  input  logic [XLEN-1:0] instr_i,
  output logic [XLEN-1:0] imm_o,
  output logic [XLEN-1:0] br_off_o
);
  localparam int unsigned OFF_W = XLEN - OP_W;
  localparam int unsigned PAD_W = XLEN - IMM_W;

  logic [IMM_W-1:0] imm_fld;
  logic             u_bit, h_bit;
  logic [OFF_W-1:0] off_fld;
  logic [XLEN-1:0]  off_ext;

  assign imm_fld = instr_i[IMM_W-1:0];
  assign u_bit   = instr_i[IMM_W];
  assign h_bit   = instr_i[IMM_W+1];

  always_comb begin
    if (h_bit)      imm_o = {imm_fld, {PAD_W{1'b0}}};
    else if (u_bit) imm_o = {{PAD_W{1'b0}}, imm_fld};
    else            imm_o = {{PAD_W{imm_fld[IMM_W-1]}}, imm_fld};
  end

  assign off_fld  = instr_i[OFF_W-1:0];
  assign off_ext  = {{OP_W{off_fld[OFF_W-1]}}, off_fld};
  assign br_off_o = {off_ext[XLEN-3:0], 2'b00};

  always_comb begin
    // R9
    imm_hi_chk: assert (!h_bit || imm_o[PAD_W-1:0] == '0)
      else $error("high immediate has nonzero low half");
    // R8
    imm_zext_chk: assert (!(u_bit && !h_bit) || imm_o[XLEN-1:IMM_W] == '0)
      else $error("zero-extended immediate has upper bits");
    // R10
    br_sign_chk: assert (br_off_o[XLEN-1] == instr_i[OFF_W-1])
      else $error("branch offset lost its sign");
  end
endmodule

// File: rtl/risc_ctrl_decoder.sv
module risc_ctrl_decoder
  import rcd_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned REG_W = 4,
  parameter int unsigned IMM_W = 16
) (
  input  logic [XLEN-1:0]    instr_i,
  output logic [NUM_OPS-1:0] op_onehot_o,
  output logic               is_imm_o,
  output logic               is_wb_o,
  output logic [REG_W-1:0]   rd_o,
  output logic [REG_W-1:0]   rs1_o,
  output logic [REG_W-1:0]   rs2_o,
  output logic [XLEN-1:0]    imm_o,
  output logic [XLEN-1:0]    br_off_o
);
  localparam int unsigned IMM_BIT = XLEN - OP_W - 1;

  logic [NUM_OPS-1:0] onehot;

  rcd_op_decode i_op_decode (
    .opcode_i  (instr_i[XLEN-1 -: OP_W]),
    .imm_bit_i (instr_i[IMM_BIT]),
    .onehot_o  (onehot),
    .is_imm_o  (is_imm_o),
    .is_wb_o   (is_wb_o)
  );

  rcd_fields #(.XLEN(XLEN), .OP_W(OP_W), .REG_W(REG_W)) i_fields (
    .instr_i   (instr_i),
    .is_call_i (onehot[OP_CALL]),
    .is_ret_i  (onehot[OP_RET]),
    .is_st_i   (onehot[OP_ST]),
    .rd_o      (rd_o),
    .rs1_o     (rs1_o),
    .rs2_o     (rs2_o)
  );

  rcd_imm #(.XLEN(XLEN), .OP_W(OP_W), .IMM_W(IMM_W)) i_imm (
    .instr_i  (instr_i),
    .imm_o    (imm_o),
    .br_off_o (br_off_o)
  );

  assign op_onehot_o = onehot;

  always_comb begin
    // R4
    wb_needs_op_chk: assert (!is_wb_o || op_onehot_o != '0)
      else $error("write-back without an operation");
    // R3
    imm_needs_op_chk: assert (!is_imm_o || instr_i[IMM_BIT])
      else $error("immediate select without bit 26");
  end
endmodule

// File: tb/test_risc_ctrl_decoder.sv
module test_risc_ctrl_decoder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr = '0;
  logic [20:0] onehot;
  logic        is_imm, is_wb;
  logic [3:0]  rd, rs1, rs2;
  logic [31:0] imm, br_off;
  int          n_vec = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  risc_ctrl_decoder i_risc_ctrl_decoder (
    .instr_i(instr), .op_onehot_o(onehot), .is_imm_o(is_imm), .is_wb_o(is_wb),
    .rd_o(rd), .rs1_o(rs1), .rs2_o(rs2), .imm_o(imm), .br_off_o(br_off)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s instr=%08h actual=%08h expected=%08h", req, instr, act, exp);
    end
  endtask

  function automatic bit exp_wb(input int op);
    case (op)
      0, 1, 2, 3, 4, 6, 7, 8, 9, 10, 11, 12, 14, 19: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit exp_imm_class(input int op);
    return (op <= 12) || op == 14 || op == 15;
  endfunction

  task automatic check_all();
    int op = int'(instr[31:27]);
    logic [31:0] e_onehot, e_imm, e_br;
    logic [3:0]  e_rd, e_rs1, e_rs2;
    e_onehot = (op < 21) ? (32'd1 << op) : 32'd0;
    chk(op < 21 ? "R1" : "R2", 32'(onehot), e_onehot);
    chk(op < 21 ? "R4" : "R2", 32'(is_wb), 32'(exp_wb(op)));
    chk(op < 21 ? "R3" : "R2", 32'(is_imm), 32'(exp_imm_class(op) & instr[26]));
    e_rd  = (op == 19) ? 4'd15 : instr[25:22];
    e_rs1 = (op == 20) ? 4'd15 : instr[21:18];
    e_rs2 = (op == 15) ? instr[25:22] : instr[17:14];
    chk(op == 19 ? "R5" : "R5", 32'(rd), 32'(e_rd));
    chk(op == 20 ? "R6" : "R5", 32'(rs1), 32'(e_rs1));
    chk(op == 15 ? "R6" : "R5", 32'(rs2), 32'(e_rs2));
    if (instr[17])      e_imm = 32'(instr[15:0]) * 32'd65536;
    else if (instr[16]) e_imm = 32'(instr[15:0]);
    else                e_imm = 32'(instr[15:0]) - (instr[15] ? 32'd65536 : 32'd0);
    chk(instr[17] ? "R9" : (instr[16] ? "R8" : "R7"), imm, e_imm);
    e_br = (32'(instr[26:0]) - (instr[26] ? 32'h0800_0000 : 32'd0)) * 32'd4;
    chk("R10", br_off, e_br);
  endtask

  initial begin
    logic [31:0] lcg = 32'h1234_5678;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #5;
    check_all(); // reset state: all-zero word decodes as add r0
    for (int op = 0; op < 32; op++) begin
      for (int k = 0; k < 48; k++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        @(negedge clk);
        instr = {5'(op), lcg[26:0]};
        if (k < 8) begin
          instr[17:16] = 2'(k);
          instr[26]    = k[2];
        end
        if (k == 8)  instr[26:0] = '1;
        if (k == 9)  instr[26:0] = 27'h400_0000;
        if (k == 10) instr[17:0] = 18'h0_8000;
        if (k == 11) instr[17:0] = 18'h1_FFFF;
        if (k == 12) instr[17:0] = 18'h3_8001;
        #5;
        check_all();
      end
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule